// File: doc/BRIEF.md
# Checkpoint Buffer with Per-Checkpoint Reference Counts

This block replaces an in-order reorder buffer. Instructions are grouped into checkpoints, and each group retires as a whole. A circular set of slots holds the checkpoints. Each slot stores the rename table's active and pending-free bit vectors, the restart PC, and a count of instructions dispatched into it that have not yet completed. The newest live slot is the current checkpoint, and its slot index is the tag attached to every dispatched instruction.

Completions can arrive in any order. Each completion lowers the count of the checkpoint named by its tag. The oldest checkpoint retires once its count is zero and a younger checkpoint exists. On retirement the block releases that group's stores and hands back a mask of physical registers to free. The mask is the pending-free snapshot taken when the following checkpoint opened, so it holds exactly the registers renamed during the retiring group. The block opens a new checkpoint on a branch, after a set number of instructions, or after a set number of stores. On a misprediction or exception it rolls back to a named checkpoint and returns that checkpoint's rename bits and restart PC.

The external rename table must clear its own pending-free bits whenever `ckpt_open` pulses. The store queue holds stores until `store_release` pulses for their checkpoint.

Top module: `ckpt_buffer`

## Requirements
- R1: After reset the buffer holds exactly one checkpoint, in slot 0, with a zero count and restart PC `RESET_PC`; `disp_ckpt_id` reads 0. At all times the number of live checkpoints is between 1 and `DEPTH`.
- R2: An accepted dispatch with `disp_branch` high opens a new checkpoint in slot (current+1) mod `DEPTH`, in the same cycle as the dispatch. That dispatch pulses `ckpt_open` and is tagged with the new slot index. The slot captures `ren_active`, `ren_pfree` and `disp_pc` as its rename snapshot and restart PC, and its count becomes 1. A dispatch that does not open a checkpoint keeps `ckpt_open` low.
- R3: An accepted dispatch that does not open a checkpoint is tagged on `disp_ckpt_id` with the current slot index and adds one to that slot's count.
- R4: A completion lowers the count of the slot given by `cmp_ckpt_id`. A dispatch and a completion to the same slot in one cycle leave its count unchanged. A checkpoint becomes eligible to retire only at count zero.
- R5: The oldest checkpoint retires in the cycle in which its count is zero and at least two checkpoints are live, unless that cycle recovers to it. `commit_valid` and `store_release` then pulse together, `commit_ckpt_id` gives the oldest slot's index, and the next slot becomes the oldest.
- R6: `free_mask` equals the pending-free snapshot stored in the slot after the retiring one while `commit_valid` is high, and is zero otherwise.
- R7: `rec_valid` with `rec_ckpt_id` = k discards every checkpoint younger than k and makes k the current checkpoint with a zero count. One cycle later `restore_valid` pulses, with k's stored active bits, pending-free bits and restart PC on `restore_active`, `restore_pfree` and `restore_pc`.
- R8: `disp_ready` is low during a recovery cycle. It is also low when all `DEPTH` slots are live and the offered dispatch would open a checkpoint. A dispatch that is refused changes no state.
- R9: A new checkpoint is also opened by the first dispatch after the current checkpoint holds `INSN_LIMIT` instructions or `STORE_LIMIT` stores (a dispatch with `disp_store` high counts as a store). Both tallies restart when a checkpoint opens, counting the opening dispatch, and restart at zero on recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_branch | input | 1 | Offered instruction is a branch |
| disp_store | input | 1 | Offered instruction is a store |
| disp_pc | input | PC_W | PC of the offered instruction |
| ren_active | input | NPR | Rename table active bits before this instruction |
| ren_pfree | input | NPR | Rename table pending-free bits before this instruction |
| disp_ready | output | 1 | Dispatch is accepted this cycle |
| disp_ckpt_id | output | IDW | Checkpoint tag for the offered instruction |
| ckpt_open | output | 1 | This dispatch opens a new checkpoint |
| cmp_valid | input | 1 | An instruction completed |
| cmp_ckpt_id | input | IDW | Tag of the completed instruction |
| rec_valid | input | 1 | Roll back to a checkpoint |
| rec_ckpt_id | input | IDW | Checkpoint to roll back to |
| restore_valid | output | 1 | Restore data is valid |
| restore_active | output | NPR | Active bits to write back into the rename table |
| restore_pfree | output | NPR | Pending-free bits to write back into the rename table |
| restore_pc | output | PC_W | Restart address |
| commit_valid | output | 1 | Oldest checkpoint retires this cycle |
| commit_ckpt_id | output | IDW | Index of the retiring checkpoint |
| store_release | output | 1 | Release the retiring checkpoint's stores |
| free_mask | output | NPR | Physical registers to return to the free pool |

## Verification
The assertions check on every cycle that occupancy stays between one and `DEPTH`. They also check that an open without a retirement grows occupancy by one, that no checkpoint opens while the buffer is full, that a retirement advances the oldest pointer by one, that no register mask appears without a retirement, and that a recovery leaves the named slot current with restore data one cycle later. Only the bench's scenarios can show the values themselves. These include the tag each instruction receives, the exact cycle a group retires after its last out-of-order completion, and that the freed mask is the snapshot taken one checkpoint later. They also include the instruction and store thresholds, and the contents returned on a rollback.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

   // Why the current dispatch must start a new checkpoint
   typedef enum logic [1:0] {
      OPEN_NONE   = 2'd0,
      OPEN_BRANCH = 2'd1,
      OPEN_INSN   = 2'd2,
      OPEN_STORE  = 2'd3
   } open_cause_e;

endpackage

// File: rtl/ckpt_trigger.sv
module ckpt_trigger
   import ckpt_pkg::*;
#(
   parameter int INSN_LIMIT  = 16,
   parameter int STORE_LIMIT = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        is_branch_i,
   input  logic        is_store_i,
   input  logic        accept_i,
   input  logic        restart_i,
   output open_cause_e cause_o
);

   localparam int IW = $clog2(INSN_LIMIT + 1);

   logic [IW-1:0] insn_q;
   logic          store_full;
   logic          opening;

   always_comb begin
      if (is_branch_i)                    cause_o = OPEN_BRANCH;
      else if (insn_q >= IW'(INSN_LIMIT)) cause_o = OPEN_INSN;
      else if (store_full)                cause_o = OPEN_STORE;
      else                                cause_o = OPEN_NONE;
   end

   assign opening = accept_i && (cause_o != OPEN_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n)         insn_q <= '0;
      else if (restart_i) insn_q <= '0;
      else if (opening)   insn_q <= IW'(1);
      else if (accept_i)  insn_q <= insn_q + 1'b1;
   end

   generate
      if (STORE_LIMIT > 0) begin : g_store
         localparam int SW = $clog2(STORE_LIMIT + 1);
         logic [SW-1:0] st_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         st_q <= '0;
            else if (restart_i) st_q <= '0;
            else if (opening)   st_q <= SW'(is_store_i);
            else if (accept_i)  st_q <= st_q + SW'(is_store_i);
         end
         assign store_full = (st_q >= SW'(STORE_LIMIT));
      end else begin : g_nostore
         assign store_full = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ckpt_slot.sv
module ckpt_slot #(
   parameter int              NPR     = 32,
   parameter int              PC_W    = 32,
   parameter int              CW      = 5,
   parameter logic [PC_W-1:0] INIT_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [NPR-1:0]  act_i,
   input  logic [NPR-1:0]  pfree_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic            inc_i,
   input  logic            dec_i,
   input  logic            clr_i,
   output logic [NPR-1:0]  act_o,
   output logic [NPR-1:0]  pfree_o,
   output logic [PC_W-1:0] pc_o,
   output logic [CW-1:0]   cnt_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_o   <= '0;
         pfree_o <= '0;
         pc_o    <= INIT_PC;
      end else if (load_i) begin
         act_o   <= act_i;
         pfree_o <= pfree_i;
         pc_o    <= pc_i;
      end
   end

   // Outstanding count: the opening dispatch counts as one
   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_o <= '0;
      else if (clr_i)            cnt_o <= '0;
      else if (load_i)           cnt_o <= CW'(1);
      else if (inc_i && !dec_i)  cnt_o <= cnt_o + 1'b1;
      else if (dec_i && !inc_i)  cnt_o <= cnt_o - 1'b1;
   end

endmodule

// File: rtl/ckpt_buffer.sv
module ckpt_buffer
   import ckpt_pkg::*;
#(
   parameter int          DEPTH       = 8,
   parameter int          NPR         = 64,
   parameter int          PC_W        = 32,
   parameter int          INSN_LIMIT  = 16,
   parameter int          STORE_LIMIT = 8,
   parameter int unsigned RESET_PC    = 0,
   localparam int         IDW         = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            disp_valid,
   input  logic            disp_branch,
   input  logic            disp_store,
   input  logic [PC_W-1:0] disp_pc,
   input  logic [NPR-1:0]  ren_active,
   input  logic [NPR-1:0]  ren_pfree,
   output logic            disp_ready,
   output logic [IDW-1:0]  disp_ckpt_id,
   output logic            ckpt_open,
   input  logic            cmp_valid,
   input  logic [IDW-1:0]  cmp_ckpt_id,
   input  logic            rec_valid,
   input  logic [IDW-1:0]  rec_ckpt_id,
   output logic            restore_valid,
   output logic [NPR-1:0]  restore_active,
   output logic [NPR-1:0]  restore_pfree,
   output logic [PC_W-1:0] restore_pc,
   output logic            commit_valid,
   output logic [IDW-1:0]  commit_ckpt_id,
   output logic            store_release,
   output logic [NPR-1:0]  free_mask
);

   localparam int              NW       = $clog2(DEPTH + 1);
   localparam int              CW       = $clog2(INSN_LIMIT + 1);
   localparam logic [PC_W-1:0] RST_PC_V = PC_W'(RESET_PC);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ckpt_buffer: DEPTH must be a power of two of at least 2");
      end
      if (INSN_LIMIT < 1) begin : g_bad_insn
         $error("ckpt_buffer: INSN_LIMIT must be at least 1");
      end
      if (STORE_LIMIT < 0 || NPR < 1 || PC_W < 1) begin : g_bad_misc
         $error("ckpt_buffer: STORE_LIMIT, NPR or PC_W out of range");
      end
   endgenerate

   // Queue pointers
   logic [IDW-1:0] head_q, tail_q;
   logic [IDW-1:0] head_inc, tail_inc, head_nx, span;
   logic [NW-1:0]  count_q, count_nx;

   // Slot contents
   logic [NPR-1:0]  s_act   [DEPTH];
   logic [NPR-1:0]  s_pfree [DEPTH];
   logic [PC_W-1:0] s_pc    [DEPTH];
   logic [CW-1:0]   s_cnt   [DEPTH];

   open_cause_e cause;
   logic        need_open, full, disp_go, open_go, commit_go;

   assign head_inc = head_q + 1'b1;
   assign tail_inc = tail_q + 1'b1;
   assign full     = (count_q == NW'(DEPTH));

   ckpt_trigger #(
      .INSN_LIMIT (INSN_LIMIT),
      .STORE_LIMIT(STORE_LIMIT)
   ) u_trigger (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_branch_i(disp_branch),
      .is_store_i (disp_store),
      .accept_i   (disp_go),
      .restart_i  (rec_valid),
      .cause_o    (cause)
   );

   assign need_open    = (cause != OPEN_NONE);
   assign disp_ready   = !rec_valid && !(need_open && full);
   assign disp_go      = disp_valid && disp_ready;
   assign open_go      = disp_go && need_open;
   assign ckpt_open    = open_go;
   assign disp_ckpt_id = need_open ? tail_inc : tail_q;

   // Retirement of the oldest group
   assign commit_go      = (count_q > NW'(1)) && (s_cnt[head_q] == '0)
                           && !(rec_valid && (rec_ckpt_id == head_q));
   assign commit_valid   = commit_go;
   assign store_release  = commit_go;
   assign commit_ckpt_id = head_q;
   assign free_mask      = commit_go ? s_pfree[head_inc] : '0;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         localparam logic [PC_W-1:0] IPC = (g == 0) ? RST_PC_V : '0;
         ckpt_slot #(
            .NPR    (NPR),
            .PC_W   (PC_W),
            .CW     (CW),
            .INIT_PC(IPC)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (open_go && (tail_inc == IDW'(g))),
            .act_i  (ren_active),
            .pfree_i(ren_pfree),
            .pc_i   (disp_pc),
            .inc_i  (disp_go && !open_go && (tail_q == IDW'(g))),
            .dec_i  (cmp_valid && (cmp_ckpt_id == IDW'(g))),
            .clr_i  (rec_valid && (rec_ckpt_id == IDW'(g))),
            .act_o  (s_act[g]),
            .pfree_o(s_pfree[g]),
            .pc_o   (s_pc[g]),
            .cnt_o  (s_cnt[g])
         );
      end
   endgenerate

   always_comb begin
      head_nx = commit_go ? head_inc : head_q;
      span    = rec_ckpt_id - head_nx;
      if (rec_valid) count_nx = NW'(span) + NW'(1);
      else           count_nx = count_q + NW'(open_go) - NW'(commit_go);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= NW'(1);
      end else begin
         head_q  <= head_nx;
         count_q <= count_nx;
         if (rec_valid)    tail_q <= rec_ckpt_id;
         else if (open_go) tail_q <= tail_inc;
      end
   end

   // Rollback data, one cycle after the request
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         restore_valid  <= 1'b0;
         restore_active <= '0;
         restore_pfree  <= '0;
         restore_pc     <= '0;
      end else begin
         restore_valid <= rec_valid;
         if (rec_valid) begin
            restore_active <= s_act[rec_ckpt_id];
            restore_pfree  <= s_pfree[rec_ckpt_id];
            restore_pc     <= s_pc[rec_ckpt_id];
         end
      end
   end

endmodule

// File: rtl/ckpt_buffer_chk.sv
module ckpt_buffer_chk #(
   parameter int DEPTH = 8,
   parameter int IDW   = 3,
   parameter int NW    = 4,
   parameter int NPR   = 64
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NW-1:0]  count_q,
   input logic [IDW-1:0] head_q,
   input logic [IDW-1:0] tail_q,
   input logic           commit_valid,
   input logic           ckpt_open,
   input logic           rec_valid,
   input logic [IDW-1:0] rec_ckpt_id,
   input logic           restore_valid,
   input logic [NPR-1:0] free_mask
);

   AST_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q >= NW'(1)) && (count_q <= NW'(DEPTH))); // R1

   AST_OPEN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      ckpt_open && !commit_valid |=> count_q == NW'($past(count_q) + 1'b1)); // R2

   AST_NO_OPEN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == NW'(DEPTH)) |-> !ckpt_open); // R8

   AST_COMMIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid && !rec_valid |=> head_q == IDW'($past(head_q) + 1'b1)); // R5

   AST_MASK_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (free_mask != '0) |-> commit_valid); // R6

   AST_RESTORE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |=> restore_valid && (tail_q == $past(rec_ckpt_id))); // R7

endmodule

bind ckpt_buffer ckpt_buffer_chk #(
   .DEPTH(DEPTH),
   .IDW  (IDW),
   .NW   (NW),
   .NPR  (NPR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .count_q      (count_q),
   .head_q       (head_q),
   .tail_q       (tail_q),
   .commit_valid (commit_valid),
   .ckpt_open    (ckpt_open),
   .rec_valid    (rec_valid),
   .rec_ckpt_id  (rec_ckpt_id),
   .restore_valid(restore_valid),
   .free_mask    (free_mask)
);

// File: tb/test_ckpt_buffer.sv
module test_ckpt_buffer;

   localparam int DEPTH = 4;
   localparam int NPR   = 8;
   localparam int PC_W  = 16;
   localparam int ILIM  = 4;
   localparam int SLIM  = 2;
   localparam int RPC   = 32'h40;
   localparam int IDW   = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            dv, dbr, dst, cv, rv;
   logic [PC_W-1:0] dpc;
   logic [NPR-1:0]  ra, rp;
   logic [IDW-1:0]  cid, rid;

   logic            disp_ready, ckpt_open, restore_valid, commit_valid, store_release;
   logic [IDW-1:0]  disp_ckpt_id, commit_ckpt_id;
   logic [NPR-1:0]  restore_active, restore_pfree, free_mask;
   logic [PC_W-1:0] restore_pc;

   ckpt_buffer #(
      .DEPTH(DEPTH), .NPR(NPR), .PC_W(PC_W),
      .INSN_LIMIT(ILIM), .STORE_LIMIT(SLIM), .RESET_PC(RPC)
   ) i_ckpt_buffer (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(dv), .disp_branch(dbr), .disp_store(dst), .disp_pc(dpc),
      .ren_active(ra), .ren_pfree(rp),
      .disp_ready(disp_ready), .disp_ckpt_id(disp_ckpt_id), .ckpt_open(ckpt_open),
      .cmp_valid(cv), .cmp_ckpt_id(cid),
      .rec_valid(rv), .rec_ckpt_id(rid),
      .restore_valid(restore_valid), .restore_active(restore_active),
      .restore_pfree(restore_pfree), .restore_pc(restore_pc),
      .commit_valid(commit_valid), .commit_ckpt_id(commit_ckpt_id),
      .store_release(store_release), .free_mask(free_mask)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Reference model state
   logic [NPR-1:0]  m_act [DEPTH];
   logic [NPR-1:0]  m_pf  [DEPTH];
   logic [PC_W-1:0] m_pc  [DEPTH];
   int              m_cnt [DEPTH];
   int              m_head, m_tail, m_count, m_icnt, m_scnt;
   logic            m_rv;
   logic [NPR-1:0]  m_ra, m_rp;
   logic [PC_W-1:0] m_rpc;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      dv = 0; dbr = 0; dst = 0; dpc = '0; ra = '0; rp = '0;
      cv = 0; cid = '0; rv = 0; rid = '0;
   endtask

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) begin
         m_act[i] = '0; m_pf[i] = '0; m_pc[i] = '0; m_cnt[i] = 0;
      end
      m_pc[0] = PC_W'(RPC);
      m_head = 0; m_tail = 0; m_count = 1; m_icnt = 0; m_scnt = 0;
      m_rv = 0; m_ra = '0; m_rp = '0; m_rpc = '0;
   endtask

   // Called just after a falling edge with inputs set; returns after the next falling edge
   task automatic step();
      int   nxt  = (m_tail + 1) % DEPTH;
      bit   need = dbr || (m_icnt >= ILIM) || (m_scnt >= SLIM);
      bit   rdy  = !rv && (!need || m_count != DEPTH);
      bit   go   = dv && rdy;
      bit   opn  = go && need;
      int   eid  = opn ? nxt : m_tail;
      bit   com  = (m_count > 1) && (m_cnt[m_head] == 0) && !(rv && (int'(rid) == m_head));
      logic [NPR-1:0] emask = com ? m_pf[(m_head + 1) % DEPTH] : '0;
      #1;
      chk("R8 disp_ready", 32'(disp_ready), 32'(rdy));
      if (go) chk(opn ? "R2 tag of opening dispatch" : "R3 tag of dispatch",
                  32'(disp_ckpt_id), 32'(eid));
      chk(opn ? (dbr ? "R2 open on branch" : "R9 open on threshold") : "R2 ckpt_open idle",
          32'(ckpt_open), 32'(opn));
      chk("R4 commit eligibility", 32'(commit_valid), 32'(com));
      chk("R5 store_release", 32'(store_release), 32'(com));
      if (com) chk("R5 commit_ckpt_id", 32'(commit_ckpt_id), 32'(m_head));
      chk("R6 free_mask", 32'(free_mask), 32'(emask));
      chk("R7 restore_valid", 32'(restore_valid), 32'(m_rv));
      if (m_rv) begin
         chk("R7 restore_active", 32'(restore_active), 32'(m_ra));
         chk("R7 restore_pfree", 32'(restore_pfree), 32'(m_rp));
         chk("R7 restore_pc", 32'(restore_pc), 32'(m_rpc));
      end
      @(posedge clk);
      m_rv = rv;
      if (rv) begin
         m_ra = m_act[rid]; m_rp = m_pf[rid]; m_rpc = m_pc[rid];
      end
      if (cv) m_cnt[cid]--;
      if (opn) begin
         m_cnt[nxt] = 1; m_act[nxt] = ra; m_pf[nxt] = rp; m_pc[nxt] = dpc;
         m_tail = nxt; m_icnt = 1; m_scnt = int'(dst); m_count++;
      end else if (go) begin
         m_cnt[m_tail]++; m_icnt++; m_scnt += int'(dst);
      end
      if (com) begin
         m_head = (m_head + 1) % DEPTH; m_count--;
      end
      if (rv) begin
         m_cnt[rid] = 0; m_tail = int'(rid);
         m_count = ((int'(rid) - m_head + DEPTH) % DEPTH) + 1;
         m_icnt = 0; m_scnt = 0;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 initial tag", 32'(disp_ckpt_id), 32'd0);
      chk("R1 no commit after reset", 32'(commit_valid), 32'd0);
      chk("R1 no restore after reset", 32'(restore_valid), 32'd0);
      @(negedge clk);
      step(); step();

      // Instruction threshold: four plain dispatches, the fifth opens slot 1
      for (int i = 0; i < ILIM; i++) begin
         idle(); dv = 1; dpc = PC_W'(16'h100 + i); step();
      end
      idle(); dv = 1; dpc = 16'h200; ra = 8'h3C; rp = 8'hA5; step();
      // Out-of-order completions drain slot 0; it then retires with mask A5
      for (int i = 0; i < ILIM; i++) begin
         idle(); cv = 1; cid = '0; step();
      end
      idle(); step();
      // Store threshold: two stores, then any dispatch opens
      idle(); dv = 1; dst = 1; dpc = 16'h210; step();
      idle(); dv = 1; dst = 1; dpc = 16'h214; step();
      idle(); dv = 1; dpc = 16'h218; ra = 8'h0F; rp = 8'h11; step();
      // Branches fill the buffer, then stall
      for (int i = 0; i < 4; i++) begin
         idle(); dv = 1; dbr = 1; dpc = PC_W'(16'h300 + 4 * i);
         ra = NPR'(i + 1); rp = NPR'(8'h80 >> i); step();
      end
      // Dispatch and completion to the same checkpoint in one cycle
      idle(); dv = 1; dpc = 16'h320; cv = 1; cid = IDW'(m_tail); step();
      // Roll back to slot 2 and read the restore port
      idle(); rv = 1; rid = 2'd2; step();
      idle(); step();

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         idle();
         dv  = ($urandom % 3) != 0;
         dbr = ($urandom % 6) == 0;
         dst = ($urandom % 4) == 0;
         dpc = PC_W'($urandom);
         ra  = NPR'($urandom);
         rp  = NPR'($urandom);
         if (($urandom % 2) == 0) begin
            int st = int'($urandom % m_count);
            for (int j = 0; j < m_count; j++) begin
               int s = (m_head + (st + j) % m_count) % DEPTH;
               if (!cv && m_cnt[s] > 0) begin
                  cv = 1; cid = IDW'(s);
               end
            end
         end
         if (($urandom % 50) == 0) begin
            rv  = 1;
            rid = IDW'((m_head + int'($urandom % m_count)) % DEPTH);
         end
         step();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule